// File: doc/BRIEF.md
# Memory map mode selector

This block holds the map-type setting of an 8-bit CPU address multiplexer and turns each CPU bus cycle into a 3-bit device-select code and an active-low write strobe for dynamic RAM. A single flag picks one of two maps. In the mixed map, the upper part of the address space shows three ROM windows. In the all-RAM map, reads in those windows go to RAM and writes go to RAM as well.

The CPU changes the map by writing to one of two control addresses. Writing $FFDF selects the all-RAM map, and writing $FFDE selects the mixed RAM/ROM map. The data written does not matter.

Each bus cycle takes two clock periods. The `half` input tells the block which half of the cycle is running. The select code is decoded without delay from the address, the read/write line and the flag. The RAM write strobe is driven only in the second half of a write cycle.

Top module: `map_mode_sel`

## Requirements
- R1: After reset the flag selects the mixed RAM/ROM map, so a read of $8000 gives select code 1.
- R2: A write cycle to $FFDF sets the all-RAM map, and a write cycle to $FFDE sets the mixed map. The flag changes at the clock edge that ends the second half of that write, so the new map applies from the next bus cycle.
- R3: An access to $FFDE or $FFDF gives select code 7 and leaves `ram_we_n` high (1).
- R4: In the mixed map, any access in $8000–$9FFF gives code 1, in $A000–$BFFF gives code 2, and in $C000–$FEFF gives code 3. This holds for reads and for writes, and `ram_we_n` stays high.
- R5: In the all-RAM map, reads in $8000–$FEFF give code 0 with `ram_we_n` high.
- R6: In the all-RAM map, writes in $8000–$FEFF give code 7. `ram_we_n` is low (0) only while `half` is 1.
- R7: In either map, addresses $0000–$7FFF give code 0. A write there drives `ram_we_n` low only while `half` is 1, and a read never drives it low.
- R8: Addresses $FF00–$FFFF other than the two control addresses give code 7 with `ram_we_n` high, for reads and for writes.
- R9: Reads of the control addresses, and writes to any other address, leave the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| half | input | 1 | 0 = first half of bus cycle, 1 = second half |
| addr | input | 16 | CPU address |
| rd | input | 1 | 1 = read cycle, 0 = write cycle |
| dev_sel | output | 3 | Device-select code |
| ram_we_n | output | 1 | Active-low DRAM write enable |

## Verification
The assertions assume that `half` alternates 0 then 1 on successive clocks. They also assume that `addr` and `rd` stay constant through both halves of a bus cycle. Under these assumptions the flag update and the write-strobe timing have a defined meaning. The bench drives every access through a single task that sets the address and direction once, then steps `half` through both values. It changes inputs only on falling edges, so the stimulus always stays within these assumptions.

// File: rtl/map_mode_sel.sv
module map_mode_sel #(
  parameter int AW = 16,
  parameter logic [AW-1:0] CTL_RAM = 16'hFFDF,
  parameter logic [AW-1:0] CTL_ROM = 16'hFFDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  output logic [2:0]    dev_sel,
  output logic          ram_we_n
);

  logic map_ram;
  logic io_page, hi_win, ctl_hit, ctl_wr;
  logic [2:0] rom_code;

  assign io_page = &addr[AW-1:AW-8];
  assign hi_win  = addr[AW-1] && !io_page;
  assign ctl_hit = (addr == CTL_RAM) || (addr == CTL_ROM);
  assign ctl_wr  = ctl_hit && !rd && half;
  assign rom_code = addr[AW-2] ? 3'd3 : {1'b0, addr[AW-2:AW-3]} + 3'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      map_ram <= 1'b0;
    else if (ctl_wr) map_ram <= (addr == CTL_RAM);

  always_comb begin
    dev_sel  = 3'd0;
    ram_we_n = 1'b1;
    if (io_page) begin
      dev_sel = 3'd7;
    end else if (hi_win) begin
      if (!map_ram) dev_sel = rom_code;
      else if (!rd) begin
        dev_sel  = 3'd7;
        ram_we_n = !half;
      end
    end else begin
      ram_we_n = rd || !half;
    end
  end

  assert_we_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (half && !rd));
  assert_read_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> ram_we_n);
  assert_low_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[AW-1] |-> dev_sel == 3'd0);
  assert_io_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_page |-> (dev_sel == 3'd7 && ram_we_n));
  assert_rom_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_win && !map_ram) |-> (dev_sel != 3'd0 && dev_sel != 3'd7 && ram_we_n));
  assert_set_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !rd && addr == CTL_RAM) |=> map_ram);
  assert_set_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !rd && addr == CTL_ROM) |=> !map_ram);
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(half && !rd && ctl_hit) |=> $stable(map_ram));

endmodule

// File: tb/sim_map_mode_sel.sv
`timescale 1ns/1ps
module sim_map_mode_sel;
  logic clk = 0, rst_n = 0, half = 0, rd = 1;
  logic [15:0] addr = 16'h0000;
  logic [2:0] dev_sel;
  logic ram_we_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  map_mode_sel u0 (.clk, .rst_n, .half, .addr, .rd, .dev_sel, .ram_we_n);

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one bus cycle; checks select in both halves and strobe per half
  task automatic acc(string tag, logic [15:0] a, logic r, int es, bit we2);
    @(negedge clk); addr = a; rd = r; half = 0;
    #1; chk({tag, " sel h0"}, dev_sel, es); chk({tag, " we h0"}, ram_we_n, 1);
    @(negedge clk); half = 1;
    #1; chk({tag, " sel h1"}, dev_sel, es); chk({tag, " we h1"}, ram_we_n, we2 ? 0 : 1);
  endtask

  task automatic t_reset;
    acc("R1 reset map", 16'h8000, 1, 1, 0);
  endtask

  task automatic t_low_ram(string m);
    acc({"R7 rd ", m}, 16'h0000, 1, 0, 0);
    acc({"R7 wr ", m}, 16'h1234, 0, 0, 1);
    acc({"R7 wr top ", m}, 16'h7FFF, 0, 0, 1);
  endtask

  task automatic t_rom_map;
    acc("R4 rd 8000", 16'h8000, 1, 1, 0);
    acc("R4 wr 9FFF", 16'h9FFF, 0, 1, 0);
    acc("R4 rd A000", 16'hA000, 1, 2, 0);
    acc("R4 wr BFFF", 16'hBFFF, 0, 2, 0);
    acc("R4 wr C000", 16'hC000, 0, 3, 0);
    acc("R4 rd FEFF", 16'hFEFF, 1, 3, 0);
  endtask

  task automatic t_to_ram;
    acc("R3 wr FFDF", 16'hFFDF, 0, 7, 0);
    acc("R2 ram map now", 16'h8000, 1, 0, 0);
  endtask

  task automatic t_ram_map;
    acc("R5 rd A000", 16'hA000, 1, 0, 0);
    acc("R5 rd FEFF", 16'hFEFF, 1, 0, 0);
    acc("R6 wr 8000", 16'h8000, 0, 7, 1);
    acc("R6 wr BFFF", 16'hBFFF, 0, 7, 1);
    acc("R6 wr C000", 16'hC000, 0, 7, 1);
  endtask

  task automatic t_io;
    acc("R8 rd FF00", 16'hFF00, 1, 7, 0);
    acc("R8 wr FFDD", 16'hFFDD, 0, 7, 0);
    acc("R8 wr FFFF", 16'hFFFF, 0, 7, 0);
    acc("R3 rd FFDE", 16'hFFDE, 1, 7, 0);
  endtask

  task automatic t_ignore;
    acc("R9 after rd FFDE", 16'h9000, 1, 0, 0);
    acc("R9 wr FFE0", 16'hFFE0, 0, 7, 0);
    acc("R9 after wr FFE0", 16'hA000, 0, 7, 1);
  endtask

  task automatic t_to_rom;
    acc("R3 wr FFDE", 16'hFFDE, 0, 7, 0);
    acc("R2 rom map back", 16'hC000, 0, 3, 0);
    acc("R9 rd FFDF", 16'hFFDF, 1, 7, 0);
    acc("R9 still rom", 16'h8000, 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_low_ram("rom");
    t_rom_map();
    t_to_ram();
    t_low_ram("ram");
    t_ram_map();
    t_io();
    t_ignore();
    t_to_rom();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule